// File: doc/BRIEF.md
# Criticality-Weighted Core Quota Splitter

This block serves one group of cores that run the threads of a single application. During each control period it counts, for every core, two kinds of cache events. The first is a first-level miss that is served by the second level. The second is a first-level miss that also misses the second level. When the period closes, it turns these counts into a criticality score per core. The more stall cycles a core's thread has suffered, the slower it is running, and the larger its score. The frequency quota granted to the group is then shared among the member cores in proportion to those scores, so that lagging threads get more clock. Each core's share is finally reduced to an index into an eight-step frequency table.

The score weights each second-level miss by a programmable ratio. This ratio is the cost in CPU cycles of a second-level miss divided by the cost of a first-level miss. The split is done by one sequential divider that is shared by all cores, under a small controller. The controller has these states:

- IDLE waits for a period boundary. Transition "boundary" goes to SCORE.
- SCORE forms all scores, their sum and the member count. Transition "scored" goes to LAUNCH.
- LAUNCH starts one division for the current core. Transition "issued" goes to WAIT.
- WAIT holds until the quotient is ready. Transition "next core" goes back to LAUNCH. Transition "last core" goes to PUBLISH.
- PUBLISH drives all new levels at once. Transition "published" returns to IDLE.

Top module: `crit_quota_splitter`

## Requirements
- R1: Each core has two separate event inputs, one for first-level misses served by the second level and one for misses that also miss the second level. Each input is counted in its own counter, so the two kinds never mix.
- R2: When `period_end` is high, every counter hands its count to the split and restarts. An event that arrives in that same cycle is the first event of the new period.
- R3: A counter that reaches all ones holds that value until the next period boundary and never wraps.
- R4: The score is computed as hit_count + miss_count × ratio. `penalty_ratio` is unsigned with 4 fractional bits, so 16 means 1.0.
- R5: Only cores whose bit is set in `member_mask` take part in the split. A member core's share is score × group quota / sum of member scores, truncated. A core outside the mask gets level index 0, and its events do not affect the other cores.
- R6: When the mask holds exactly one core, that core's share is the whole group quota, whatever its counts are.
- R7: When every member core scores zero, each member gets the group quota divided by the number of members.
- R8: `group_quota` is unsigned with 8 fractional bits, so 256 means one core at peak frequency. Output index i stands for (i+1)/8 of peak. A share is rounded down to the nearest table entry. A share below 1/8 gives index 0, and a share of 1.0 or more gives index 7.
- R9: All per-core levels change together in the single cycle in which `level_valid` is high. `level_valid` is a one-cycle pulse, and between pulses the levels hold.
- R10: After reset, every level index is 0 and `level_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_evt | input | NCORES | Per core: one first-level miss served by the second level this cycle |
| miss_evt | input | NCORES | Per core: one miss that also missed the second level this cycle |
| period_end | input | 1 | Control period boundary; quota, ratio and mask are sampled with it |
| group_quota | input | QFRAC+1+clog2(NCORES) | Group frequency quota, 8 fractional bits |
| penalty_ratio | input | RATIO_W | Second-level to first-level penalty ratio, 4 fractional bits |
| member_mask | input | NCORES | Cores belonging to the group |
| level_o | output | NCORES×3 | Frequency table index per core, core 0 in the lowest bits |
| level_valid | output | 1 | One-cycle pulse when new levels are driven |

## Verification
The assertions assume that `period_end` comes only while the controller is idle. One split takes about NCORES × (NUM_W + 3) cycles. A boundary that arrives during a split would replace the snapshot being split, and it is deliberately not handled. The assertions also assume that the quota is no larger than NCORES × 1.0. The stimulus only raises `period_end` after it has seen `level_valid` from the previous split. It keeps the quotas between 31 and 768, which is within the four-core range.

// File: rtl/qs_pkg.sv
package qs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCORE,
        S_LAUNCH,
        S_WAIT,
        S_PUBLISH
    } split_state_e;

    typedef enum logic [1:0] {
        D_IDLE,
        D_RUN,
        D_DONE
    } div_state_e;

endpackage

// File: rtl/qs_miss_counter.sv
module qs_miss_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             period_end,
    output logic [CNT_W-1:0] snap_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            snap_o <= '0;
        end else if (period_end) begin
            snap_o <= cnt_q;
            cnt_q  <= {{(CNT_W-1){1'b0}}, evt};
        end else if (evt && cnt_q != MAXV) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_end && cnt_q == MAXV) |=> (cnt_q == MAXV));

    // R2
    boundary_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (cnt_q <= 1 && snap_o == $past(cnt_q)));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_end) |-> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/qs_divider.sv
module qs_divider
    import qs_pkg::*;
#(
    parameter int NUM_W = 36,
    parameter int DEN_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int IT_W = $clog2(NUM_W + 1);
    localparam int PW   = NUM_W + DEN_W + 1;

    div_state_e state_q, state_d;
    logic [NUM_W-1:0] n_q, quo_q;
    logic [DEN_W-1:0] d_q;
    logic [DEN_W:0]   rem_q;
    logic [IT_W-1:0]  it_q;
    logic [DEN_W:0]   trial;
    logic             ge;

    assign trial = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    assign ge    = (trial >= {1'b0, d_q});

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            D_IDLE: if (start) state_d = D_RUN;
            D_RUN:  if (it_q == IT_W'(NUM_W - 1)) state_d = D_DONE;
            D_DONE: state_d = D_IDLE;
            default: state_d = D_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= D_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= '0;
            d_q   <= '0;
            quo_q <= '0;
            rem_q <= '0;
            it_q  <= '0;
        end else begin
            unique case (state_q)
                D_IDLE: if (start) begin
                    n_q   <= num;
                    d_q   <= den;
                    quo_q <= num;
                    rem_q <= '0;
                    it_q  <= '0;
                end
                D_RUN: begin
                    quo_q <= {quo_q[NUM_W-2:0], ge};
                    rem_q <= ge ? (trial - {1'b0, d_q}) : trial;
                    it_q  <= it_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign done = (state_q == D_DONE);
    assign quot = quo_q;

    logic [PW-1:0] recon;
    assign recon = PW'(quo_q) * PW'(d_q) + PW'(rem_q);

    // R5
    div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (recon == PW'(n_q) && rem_q < {1'b0, d_q}));

endmodule

// File: rtl/qs_level_quant.sv
module qs_level_quant #(
    parameter int SHARE_W = 11,
    parameter int QFRAC   = 8,
    parameter int LEVELS  = 8
) (
    input  logic [SHARE_W-1:0]        share,
    output logic [$clog2(LEVELS)-1:0] idx
);
    localparam int LVL_W = $clog2(LEVELS);
    localparam int STEP_SH = QFRAC - LVL_W;
    localparam logic [SHARE_W-1:0] ONE = SHARE_W'(1) << QFRAC;

    logic [SHARE_W-1:0] k;

    always_comb begin
        k = share >> STEP_SH;
        if (share >= ONE)   idx = LVL_W'(LEVELS - 1);
        else if (k == '0)   idx = '0;
        else                idx = LVL_W'(k - 1'b1);
    end

endmodule

// File: rtl/crit_quota_splitter.sv
module crit_quota_splitter
    import qs_pkg::*;
#(
    parameter int NCORES  = 4,
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 8,
    parameter int QFRAC   = 8,
    parameter int LEVELS  = 8,
    localparam int GQ_W   = QFRAC + 1 + $clog2(NCORES),
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES-1:0]       hit_evt,
    input  logic [NCORES-1:0]       miss_evt,
    input  logic                    period_end,
    input  logic [GQ_W-1:0]         group_quota,
    input  logic [RATIO_W-1:0]      penalty_ratio,
    input  logic [NCORES-1:0]       member_mask,
    output logic [NCORES*LVL_W-1:0] level_o,
    output logic                    level_valid
);
    localparam int RFRAC  = 4;
    localparam int CRIT_W = CNT_W + RATIO_W + 1;
    localparam int SUM_W  = CRIT_W + $clog2(NCORES);
    localparam int NUM_W  = CRIT_W + GQ_W;
    localparam int DEN_W  = SUM_W;
    localparam int IDX_W  = $clog2(NCORES);
    localparam int MC_W   = $clog2(NCORES + 1);
    localparam logic [GQ_W-1:0] ONE = GQ_W'(1) << QFRAC;

    split_state_e state_q, state_d;

    logic [CNT_W-1:0]   snap_hit  [NCORES];
    logic [CNT_W-1:0]   snap_miss [NCORES];
    logic [CRIT_W-1:0]  crit_c    [NCORES];
    logic [CRIT_W-1:0]  crit_q    [NCORES];
    logic [LVL_W-1:0]   pend_q    [NCORES];
    logic [SUM_W-1:0]   sum_c, sum_q;
    logic [MC_W-1:0]    cnt_c, cnt_q;
    logic [GQ_W-1:0]    gq_q;
    logic [RATIO_W-1:0] ratio_q;
    logic [NCORES-1:0]  mask_q;
    logic [IDX_W-1:0]   idx_q;

    logic               div_start, div_done;
    logic [NUM_W-1:0]   div_num, div_quot;
    logic [DEN_W-1:0]   div_den;
    logic [GQ_W-1:0]    share;
    logic [LVL_W-1:0]   share_idx;

    // event counters, two per core (R1)
    for (genvar g = 0; g < NCORES; g++) begin : g_cnt
        qs_miss_counter #(.CNT_W(CNT_W)) u_hit (
            .clk(clk), .rst_n(rst_n), .evt(hit_evt[g]),
            .period_end(period_end), .snap_o(snap_hit[g])
        );
        qs_miss_counter #(.CNT_W(CNT_W)) u_miss (
            .clk(clk), .rst_n(rst_n), .evt(miss_evt[g]),
            .period_end(period_end), .snap_o(snap_miss[g])
        );
    end

    // criticality scores (R4)
    always_comb begin
        sum_c = '0;
        cnt_c = '0;
        for (int i = 0; i < NCORES; i++) begin
            crit_c[i] = (CRIT_W'(snap_hit[i]) << RFRAC)
                      + CRIT_W'(snap_miss[i]) * CRIT_W'(ratio_q);
            if (mask_q[i]) begin
                sum_c = sum_c + SUM_W'(crit_c[i]);
                cnt_c = cnt_c + 1'b1;
            end
        end
    end

    // division operands for the current core (R5, R6, R7)
    always_comb begin
        if (!mask_q[idx_q]) begin
            div_num = '0;
            div_den = DEN_W'(1);
        end else if (sum_q == '0) begin
            div_num = NUM_W'(gq_q);
            div_den = DEN_W'(cnt_q);
        end else begin
            div_num = NUM_W'(crit_q[idx_q]) * NUM_W'(gq_q);
            div_den = DEN_W'(sum_q);
        end
    end

    assign div_start = (state_q == S_LAUNCH);

    qs_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den), .done(div_done), .quot(div_quot)
    );

    assign share = div_quot[GQ_W-1:0];

    qs_level_quant #(.SHARE_W(GQ_W), .QFRAC(QFRAC), .LEVELS(LEVELS)) u_quant (
        .share(share), .idx(share_idx)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (period_end) state_d = S_SCORE;
            S_SCORE:   state_d = (cnt_c == '0) ? S_PUBLISH : S_LAUNCH;
            S_LAUNCH:  state_d = S_WAIT;
            S_WAIT:    if (div_done)
                           state_d = (idx_q == IDX_W'(NCORES - 1)) ? S_PUBLISH : S_LAUNCH;
            S_PUBLISH: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gq_q        <= '0;
            ratio_q     <= '0;
            mask_q      <= '0;
            sum_q       <= '0;
            cnt_q       <= '0;
            idx_q       <= '0;
            level_o     <= '0;
            level_valid <= 1'b0;
            for (int i = 0; i < NCORES; i++) begin
                crit_q[i] <= '0;
                pend_q[i] <= '0;
            end
        end else begin
            level_valid <= 1'b0;
            unique case (state_q)
                S_IDLE: if (period_end) begin
                    gq_q    <= group_quota;
                    ratio_q <= penalty_ratio;
                    mask_q  <= member_mask;
                end
                S_SCORE: begin
                    sum_q <= sum_c;
                    cnt_q <= cnt_c;
                    idx_q <= '0;
                    for (int i = 0; i < NCORES; i++) begin
                        crit_q[i] <= crit_c[i];
                        pend_q[i] <= '0;
                    end
                end
                S_WAIT: if (div_done) begin
                    pend_q[idx_q] <= mask_q[idx_q] ? share_idx : '0;
                    idx_q         <= idx_q + 1'b1;
                end
                S_PUBLISH: begin
                    level_valid <= 1'b1;
                    for (int i = 0; i < NCORES; i++)
                        level_o[i*LVL_W +: LVL_W] <= pend_q[i];
                end
                default: ;
            endcase
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_valid |=> !level_valid);

    // R9
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !level_valid |-> $stable(level_o));

    for (genvar g = 0; g < NCORES; g++) begin : g_chk
        // R5
        nonmember_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (level_valid && !mask_q[g]) |-> (level_o[g*LVL_W +: LVL_W] == '0));

        // R6
        single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (level_valid && mask_q == NCORES'(1 << g) && gq_q >= ONE)
                |-> (level_o[g*LVL_W +: LVL_W] == LVL_W'(LEVELS - 1)));
    end

endmodule

// File: tb/crit_quota_splitter_tb.sv
module crit_quota_splitter_tb;
    localparam int N = 4;
    localparam int LW = 3;
    localparam int GQW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] hit_evt = '0;
    logic [N-1:0] miss_evt = '0;
    logic period_end = 1'b0;
    logic [GQW-1:0] group_quota = '0;
    logic [7:0] penalty_ratio = '0;
    logic [N-1:0] member_mask = '0;
    logic [N*LW-1:0] level_o;
    logic level_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    crit_quota_splitter #(.NCORES(N), .CNT_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .miss_evt(miss_evt),
        .period_end(period_end), .group_quota(group_quota),
        .penalty_ratio(penalty_ratio), .member_mask(member_mask),
        .level_o(level_o), .level_valid(level_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lvl(input int c);
        return int'(level_o[c*LW +: LW]);
    endfunction

    task automatic hits(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) hit_evt[c] = 1'b1;
            @(negedge clk) hit_evt[c] = 1'b0;
        end
    endtask

    task automatic misses(input int c, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) miss_evt[c] = 1'b1;
            @(negedge clk) miss_evt[c] = 1'b0;
        end
    endtask

    // closes a period, optionally with a hit on core 0 in the boundary cycle,
    // and waits until the new levels are valid
    task automatic close_period(input int gq, input int ratio, input int mask,
                                input bit edge_hit);
        int t;
        @(negedge clk);
        group_quota   = GQW'(gq);
        penalty_ratio = 8'(ratio);
        member_mask   = N'(mask);
        period_end    = 1'b1;
        if (edge_hit) hit_evt[0] = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
        hit_evt[0] = 1'b0;
        t = 0;
        while (!level_valid && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check("R9 valid seen", int'(level_valid), 1);
    endtask

    task automatic after_pulse();
        int saved;
        saved = int'(level_o);
        @(negedge clk);
        check("R9 pulse width", int'(level_valid), 0);
        check("R9 hold", int'(level_o), saved);
    endtask

    task automatic t_reset();
        check("R10 levels", int'(level_o), 0);
        check("R10 valid", int'(level_valid), 0);
    endtask

    task automatic t_proportional();
        hits(0, 10);
        misses(1, 5);
        hits(2, 20);
        close_period(512, 32, 4'b1111, 1'b0);
        check("R5 core0", lvl(0), 3);
        check("R4 core1 weighted", lvl(1), 3);
        check("R8 core2 clamp high", lvl(2), 7);
        check("R8 core3 clamp low", lvl(3), 0);
        after_pulse();
    endtask

    task automatic t_kinds_separate();
        hits(0, 4);
        misses(1, 1);
        close_period(256, 64, 4'b0011, 1'b0);
        check("R1 core0", lvl(0), 3);
        check("R1 core1", lvl(1), 3);
    endtask

    task automatic t_fraction_ratio();
        hits(0, 3);
        misses(1, 4);
        hits(2, 9);
        misses(3, 7);
        close_period(384, 24, 4'b0011, 1'b0);
        check("R4 core0", lvl(0), 3);
        check("R4 core1", lvl(1), 7);
        check("R5 nonmember2", lvl(2), 0);
        check("R5 nonmember3", lvl(3), 0);
    endtask

    task automatic t_equal_split();
        close_period(768, 16, 4'b1111, 1'b0);
        for (int c = 0; c < N; c++) check("R7 equal", lvl(c), 5);
    endtask

    task automatic t_boundary();
        hits(0, 4);
        hits(1, 4);
        close_period(512, 16, 4'b0011, 1'b1);
        check("R2 period A core0", lvl(0), 7);
        check("R2 period A core1", lvl(1), 7);
        close_period(512, 16, 4'b0011, 1'b0);
        check("R2 period B core0", lvl(0), 7);
        check("R2 period B core1", lvl(1), 0);
    endtask

    task automatic t_saturate();
        hits(0, 70);
        hits(1, 63);
        close_period(512, 16, 4'b0011, 1'b0);
        check("R3 core0", lvl(0), 7);
        check("R3 core1", lvl(1), 7);
    endtask

    task automatic t_single();
        hits(2, 5);
        misses(0, 3);
        close_period(95, 16, 4'b0100, 1'b0);
        check("R6 round down", lvl(2), 1);
        check("R5 nonmember0", lvl(0), 0);
        close_period(31, 16, 4'b0100, 1'b0);
        check("R8 below lowest", lvl(2), 0);
        misses(2, 2);
        close_period(300, 16, 4'b0100, 1'b0);
        check("R6 pass clamp", lvl(2), 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_proportional();
        t_kinds_separate();
        t_fraction_ratio();
        t_equal_split();
        t_boundary();
        t_saturate();
        t_single();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule